// File: doc/BRIEF.md
# Programmable Address Window Decoder with Translation

This block sits between a CPU address source and the system interconnect and decides, for every address the CPU issues, which of eight programmable windows claims it. Each window holds a control word (size mask, destination target code, attribute byte, enable), a base address, and, for the lower-numbered windows, a pair of translation registers. A small write-only configuration port loads these registers. Software normally programs the windows once at boot and then leaves them alone.

For each incoming address the block reports whether a window claimed it, which window that was, the target code and attribute to route with, and the translated address. If no window claims the address, a miss flag is raised. The decode is purely combinational by default. A parameter inserts one register stage on all decode outputs.

Window size is a count of 64 KB granules, expressed as a run of ones from the low end of a 16-bit mask. Translation swaps in replacement bits only at address positions the mask does not cover, so offsets inside the window are preserved.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every window is disabled, so every address reports a miss until a window is programmed.
- R2: A window whose enable bit (control bit 0) is clear never claims an address, whatever its base and size hold.
- R3: The size mask lives in control bits 31:16, and bit k of the mask covers address bit 16+k. A window claims an address when the address agrees with the base on every bit from 31 to 16 that the mask leaves at zero. For example, mask 0x00FF with base 0x1000_0000 claims 0x1000_0000 through 0x10FF_FFFF.
- R4: A mask of all zeros gives a single 64 KB granule. With base 0x2000_0000, the address 0x2000_FFFF is claimed and 0x2001_0000 is not.
- R5: For translating windows (0 to 3), bits 31:16 of the translated address come from the low translation register where the mask is zero and from the incoming address where the mask is one. Bits 15:0 are always copied from the address.
- R6: When a translating window's low translation register equals its base, the translated address equals the incoming address.
- R7: Windows 4 to 7 have no translation storage. Writes to their translation registers are discarded, their translated address equals the incoming address, and the high output is zero.
- R8: When several enabled windows claim the same address, the lowest-numbered one wins.
- R9: On a miss, the miss output is 1 and the window index, target and attribute are 0. The low translated output equals the address and the high output is 0.
- R10: A mask that is not a clean run of ones is treated as only its unbroken run of ones starting at bit 0. For example, 0x00F3 behaves as 0x0003.
- R11: A translating window drives its high translation register onto the high output on a hit.
- R12: Control word fields are target code in bits 7:4 and attribute in bits 15:8. The configuration register select is 0 for control, 1 for base, 2 for low translation and 3 for high translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | 3 | Window number for the write |
| cfg_sel | input | 2 | Register select within the window |
| cfg_wdata | input | 32 | Write data |
| cpu_addr | input | 32 | Address to decode |
| dec_miss | output | 1 | No window claims the address |
| dec_win | output | 3 | Winning window number |
| dec_tgt | output | 4 | Target code of the winning window |
| dec_attr | output | 8 | Attribute of the winning window |
| dec_addr_lo | output | 32 | Translated address |
| dec_addr_hi | output | 32 | High translation word |

## Verification
The checker watches the combinational decode ahead of the optional output register. It assumes the configuration is steady across the address being judged, which holds because a write changes state only at a clock edge and each property relates values sampled at that same edge. The bench drives configuration writes and addresses half a cycle away from the active edge. It then reads the decode before the next edge, so no address is judged against a half-written window.

// File: rtl/awd_pkg.sv
package awd_pkg;
   // configuration register select codes
   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_BASE  = 2'd1,
      SEL_XLO   = 2'd2,
      SEL_XHI   = 2'd3
   } cfg_sel_e;

   // control word field positions
   localparam int EN_BIT   = 0;
   localparam int TGT_LSB  = 4;
   localparam int ATTR_LSB = 8;
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
   import awd_pkg::*;
#(
   parameter int NUM_WIN   = 8,
   parameter int NUM_XLAT  = 4,
   parameter int DW        = 32,
   localparam int IW       = $clog2(NUM_WIN)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [IW-1:0]              win,
   input  logic [1:0]                 sel,
   input  logic [DW-1:0]              wdata,
   output logic [NUM_WIN-1:0][DW-1:0] ctrl,
   output logic [NUM_WIN-1:0][DW-1:0] base,
   output logic [NUM_WIN-1:0][DW-1:0] xlo,
   output logic [NUM_WIN-1:0][DW-1:0] xhi
);
   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic hit_w;
      assign hit_w = we && (win == IW'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctrl[w] <= '0;
            base[w] <= '0;
         end else if (hit_w) begin
            if (sel == SEL_CTRL) ctrl[w] <= wdata;
            if (sel == SEL_BASE) base[w] <= wdata;
         end
      end

      if (w < NUM_XLAT) begin : g_xlat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               xlo[w] <= '0;
               xhi[w] <= '0;
            end else if (hit_w) begin
               if (sel == SEL_XLO) xlo[w] <= wdata;
               if (sel == SEL_XHI) xhi[w] <= wdata;
            end
         end
      end else begin : g_noxlat
         assign xlo[w] = '0;
         assign xhi[w] = '0;
      end
   end
endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
   import awd_pkg::*;
#(
   parameter int DW       = 32,
   parameter int GRAN_W   = 16,
   parameter bit HAS_XLAT = 1'b1,
   localparam int SW      = DW - GRAN_W
) (
   input  logic [DW-1:0] ctrl,
   input  logic [DW-1:0] base,
   input  logic [DW-1:0] xlo,
   input  logic [DW-1:0] xhi,
   input  logic [DW-1:0] addr,
   output logic          hit,
   output logic [DW-1:0] out_lo,
   output logic [DW-1:0] out_hi
);
   logic [SW-1:0] raw_sz;
   logic [SW-1:0] mask;

   assign raw_sz = ctrl[DW-1 -: SW];

   // keep only the unbroken run of ones from bit 0
   always_comb begin
      mask[0] = raw_sz[0];
      for (int k = 1; k < SW; k++) mask[k] = mask[k-1] & raw_sz[k];
   end

   assign hit = ctrl[EN_BIT] &&
                (((addr[DW-1:GRAN_W] ^ base[DW-1:GRAN_W]) & ~mask) == '0);

   if (HAS_XLAT) begin : g_xlat
      assign out_lo = {(xlo[DW-1:GRAN_W] & ~mask) | (addr[DW-1:GRAN_W] & mask),
                       addr[GRAN_W-1:0]};
      assign out_hi = xhi;
   end else begin : g_pass
      assign out_lo = addr;
      assign out_hi = '0;
   end
endmodule

// File: rtl/awd_prio.sv
module awd_prio
   import awd_pkg::*;
#(
   parameter int NUM_WIN = 8,
   parameter int DW      = 32,
   parameter int TGT_W   = 4,
   parameter int ATTR_W  = 8,
   localparam int IW     = $clog2(NUM_WIN)
) (
   input  logic [NUM_WIN-1:0]         hit_vec,
   input  logic [NUM_WIN-1:0][DW-1:0] ctrl,
   input  logic [NUM_WIN-1:0][DW-1:0] lo_vec,
   input  logic [NUM_WIN-1:0][DW-1:0] hi_vec,
   input  logic [DW-1:0]              addr,
   output logic                       miss,
   output logic [IW-1:0]              idx,
   output logic [TGT_W-1:0]           tgt,
   output logic [ATTR_W-1:0]          attr,
   output logic [DW-1:0]              out_lo,
   output logic [DW-1:0]              out_hi
);
   logic found;

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
      miss = !found;
      if (found) begin
         tgt    = ctrl[idx][TGT_LSB +: TGT_W];
         attr   = ctrl[idx][ATTR_LSB +: ATTR_W];
         out_lo = lo_vec[idx];
         out_hi = hi_vec[idx];
      end else begin
         tgt    = '0;
         attr   = '0;
         out_lo = addr;
         out_hi = '0;
      end
   end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
   import awd_pkg::*;
#(
   parameter int NUM_WIN  = 8,
   parameter int NUM_XLAT = 4,
   parameter int ADDR_W   = 32,
   parameter int GRAN_W   = 16,
   parameter int TGT_W    = 4,
   parameter int ATTR_W   = 8,
   parameter bit REG_OUT  = 1'b0,
   localparam int IW      = $clog2(NUM_WIN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IW-1:0]     cfg_win,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              dec_miss,
   output logic [IW-1:0]     dec_win,
   output logic [TGT_W-1:0]  dec_tgt,
   output logic [ATTR_W-1:0] dec_attr,
   output logic [ADDR_W-1:0] dec_addr_lo,
   output logic [ADDR_W-1:0] dec_addr_hi
);
   if (NUM_XLAT > NUM_WIN) begin : g_bad_xlat
      $error("NUM_XLAT exceeds NUM_WIN");
   end
   if (GRAN_W >= ADDR_W) begin : g_bad_gran
      $error("GRAN_W must be below ADDR_W");
   end
   if (TGT_LSB + TGT_W > ATTR_LSB || ATTR_LSB + ATTR_W > GRAN_W) begin : g_bad_fields
      $error("control fields overlap the size mask");
   end

   logic [NUM_WIN-1:0][ADDR_W-1:0] ctrl, base, xlo, xhi, lo_vec, hi_vec;
   logic [NUM_WIN-1:0]             hit_vec;
   logic [NUM_WIN-1:0]             en_vec;

   logic              c_miss;
   logic [IW-1:0]     c_idx;
   logic [TGT_W-1:0]  c_tgt;
   logic [ATTR_W-1:0] c_attr;
   logic [ADDR_W-1:0] c_lo, c_hi;

   awd_regfile #(.NUM_WIN(NUM_WIN), .NUM_XLAT(NUM_XLAT), .DW(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .win(cfg_win), .sel(cfg_sel),
      .wdata(cfg_wdata), .ctrl(ctrl), .base(base), .xlo(xlo), .xhi(xhi)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
      assign en_vec[w] = ctrl[w][EN_BIT];
      awd_win_match #(.DW(ADDR_W), .GRAN_W(GRAN_W), .HAS_XLAT(w < NUM_XLAT)) u_win (
         .ctrl(ctrl[w]), .base(base[w]), .xlo(xlo[w]), .xhi(xhi[w]),
         .addr(cpu_addr), .hit(hit_vec[w]), .out_lo(lo_vec[w]), .out_hi(hi_vec[w])
      );
   end

   awd_prio #(.NUM_WIN(NUM_WIN), .DW(ADDR_W), .TGT_W(TGT_W), .ATTR_W(ATTR_W)) u_prio (
      .hit_vec(hit_vec), .ctrl(ctrl), .lo_vec(lo_vec), .hi_vec(hi_vec),
      .addr(cpu_addr), .miss(c_miss), .idx(c_idx), .tgt(c_tgt), .attr(c_attr),
      .out_lo(c_lo), .out_hi(c_hi)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dec_miss    <= 1'b1;
            dec_win     <= '0;
            dec_tgt     <= '0;
            dec_attr    <= '0;
            dec_addr_lo <= '0;
            dec_addr_hi <= '0;
         end else begin
            dec_miss    <= c_miss;
            dec_win     <= c_idx;
            dec_tgt     <= c_tgt;
            dec_attr    <= c_attr;
            dec_addr_lo <= c_lo;
            dec_addr_hi <= c_hi;
         end
      end
   end else begin : g_comb
      assign dec_miss    = c_miss;
      assign dec_win     = c_idx;
      assign dec_tgt     = c_tgt;
      assign dec_attr    = c_attr;
      assign dec_addr_lo = c_lo;
      assign dec_addr_hi = c_hi;
   end
endmodule

// File: rtl/awd_chk.sv
module awd_chk #(
   parameter int NUM_WIN  = 8,
   parameter int NUM_XLAT = 4,
   parameter int ADDR_W   = 32,
   parameter int GRAN_W   = 16,
   parameter int TGT_W    = 4,
   parameter int ATTR_W   = 8,
   localparam int IW      = $clog2(NUM_WIN)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [NUM_WIN-1:0] en_vec,
   input logic [NUM_WIN-1:0] hit_vec,
   input logic              c_miss,
   input logic [IW-1:0]     c_idx,
   input logic [TGT_W-1:0]  c_tgt,
   input logic [ATTR_W-1:0] c_attr,
   input logic [ADDR_W-1:0] c_lo,
   input logic [ADDR_W-1:0] c_hi
);
   // R1
   reset_all_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> c_miss);

   // R2
   winner_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !c_miss |-> en_vec[c_idx]);

   // R8
   lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !c_miss |-> ((hit_vec & ((NUM_WIN'(1) << c_idx) - NUM_WIN'(1))) == '0));

   // R9
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_miss |-> (c_tgt == '0 && c_attr == '0 && c_idx == '0 &&
                  c_lo == cpu_addr && c_hi == '0));

   // R5
   offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !c_miss |-> (c_lo[GRAN_W-1:0] == cpu_addr[GRAN_W-1:0]));

   // R7
   no_xlat_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!c_miss && int'(c_idx) >= NUM_XLAT) |-> (c_lo == cpu_addr && c_hi == '0));
endmodule

bind addr_window_decoder awd_chk #(
   .NUM_WIN(NUM_WIN), .NUM_XLAT(NUM_XLAT), .ADDR_W(ADDR_W),
   .GRAN_W(GRAN_W), .TGT_W(TGT_W), .ATTR_W(ATTR_W)
) u_awd_chk (
   .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .en_vec(en_vec),
   .hit_vec(hit_vec), .c_miss(c_miss), .c_idx(c_idx), .c_tgt(c_tgt),
   .c_attr(c_attr), .c_lo(c_lo), .c_hi(c_hi)
);

// File: tb/test_addr_window_decoder.sv
module test_addr_window_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_win = '0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cpu_addr = '0;
   logic        dec_miss;
   logic [2:0]  dec_win;
   logic [3:0]  dec_tgt;
   logic [7:0]  dec_attr;
   logic [31:0] dec_addr_lo, dec_addr_hi;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   addr_window_decoder i_addr_window_decoder (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cpu_addr(cpu_addr),
      .dec_miss(dec_miss), .dec_win(dec_win), .dec_tgt(dec_tgt),
      .dec_attr(dec_attr), .dec_addr_lo(dec_addr_lo), .dec_addr_hi(dec_addr_hi)
   );

   function automatic logic [31:0] mk_ctrl(logic [15:0] sz, logic [7:0] at,
                                           logic [3:0] tg, logic en);
      return {sz, at, tg, 3'b000, en};
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(int w, int sel, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_win = 3'(w); cfg_sel = 2'(sel); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic probe_hit(string req, logic [31:0] a, int w, logic [3:0] tg,
                            logic [7:0] at, logic [31:0] lo, logic [31:0] hi);
      @(negedge clk);
      cpu_addr = a;
      #2;
      check(req, "miss", 32'(dec_miss), 32'd0);
      check(req, "win", 32'(dec_win), 32'(w));
      check(req, "tgt", 32'(dec_tgt), 32'(tg));
      check(req, "attr", 32'(dec_attr), 32'(at));
      check(req, "lo", dec_addr_lo, lo);
      check(req, "hi", dec_addr_hi, hi);
   endtask

   task automatic probe_miss(string req, logic [31:0] a);
      @(negedge clk);
      cpu_addr = a;
      #2;
      check(req, "miss", 32'(dec_miss), 32'd1);
      check(req, "win", 32'(dec_win), 32'd0);
      check(req, "tgt", 32'(dec_tgt), 32'd0);
      check(req, "attr", 32'(dec_attr), 32'd0);
      check(req, "lo", dec_addr_lo, a);
      check(req, "hi", dec_addr_hi, 32'd0);
   endtask

   // R1 R9: nothing programmed
   task automatic t_reset();
      probe_miss("R1", 32'h0000_0000);
      probe_miss("R9", 32'hF123_4567);
   endtask

   // R3 R6 R12: 16 MB window, identity translation
   task automatic t_size();
      wr(2, 0, mk_ctrl(16'h00FF, 8'h3C, 4'h2, 1'b1));
      wr(2, 1, 32'h1000_0000);
      wr(2, 2, 32'h1000_0000);
      probe_hit("R3", 32'h1000_0000, 2, 4'h2, 8'h3C, 32'h1000_0000, 32'h0);
      probe_hit("R6", 32'h10FF_1234, 2, 4'h2, 8'h3C, 32'h10FF_1234, 32'h0);
      probe_miss("R3", 32'h1100_0000);
      probe_miss("R3", 32'h0FFF_FFFF);
   endtask

   // R4 then R2
   task automatic t_min_and_disable();
      wr(3, 0, mk_ctrl(16'h0000, 8'h11, 4'h3, 1'b1));
      wr(3, 1, 32'h2000_0000);
      wr(3, 2, 32'h2000_0000);
      probe_hit("R4", 32'h2000_FFFF, 3, 4'h3, 8'h11, 32'h2000_FFFF, 32'h0);
      probe_miss("R4", 32'h2001_0000);
      wr(3, 0, mk_ctrl(16'h0000, 8'h11, 4'h3, 1'b0));
      probe_miss("R2", 32'h2000_0000);
   endtask

   // R5 R11: 1 MB window relocated
   task automatic t_xlat();
      wr(0, 0, mk_ctrl(16'h000F, 8'hA5, 4'h7, 1'b1));
      wr(0, 1, 32'h3000_0000);
      wr(0, 2, 32'h8000_0000);
      wr(0, 3, 32'h0000_0005);
      probe_hit("R5", 32'h300A_BCDE, 0, 4'h7, 8'hA5, 32'h800A_BCDE, 32'h5);
      wr(0, 2, 32'h8005_0000);
      probe_hit("R11", 32'h300A_BCDE, 0, 4'h7, 8'hA5, 32'h800A_BCDE, 32'h5);
   endtask

   // R7: upper window, translation writes discarded
   task automatic t_pass();
      wr(5, 0, mk_ctrl(16'h0001, 8'h42, 4'h5, 1'b1));
      wr(5, 1, 32'h4000_0000);
      wr(5, 2, 32'h9000_0000);
      wr(5, 3, 32'h0000_0077);
      probe_hit("R7", 32'h4001_0042, 5, 4'h5, 8'h42, 32'h4001_0042, 32'h0);
   endtask

   // R8: overlap between window 1 and window 6
   task automatic t_prio();
      wr(6, 0, mk_ctrl(16'h00FF, 8'h66, 4'h6, 1'b1));
      wr(6, 1, 32'h5000_0000);
      wr(1, 0, mk_ctrl(16'h0000, 8'h01, 4'h1, 1'b1));
      wr(1, 1, 32'h5000_0000);
      wr(1, 2, 32'h5000_0000);
      probe_hit("R8", 32'h5000_0010, 1, 4'h1, 8'h01, 32'h5000_0010, 32'h0);
      probe_hit("R8", 32'h5001_0000, 6, 4'h6, 8'h66, 32'h5001_0000, 32'h0);
   endtask

   // R10: broken mask
   task automatic t_badmask();
      wr(4, 0, mk_ctrl(16'h00F3, 8'h99, 4'h4, 1'b1));
      wr(4, 1, 32'h6000_0000);
      probe_hit("R10", 32'h6003_0000, 4, 4'h4, 8'h99, 32'h6003_0000, 32'h0);
      probe_miss("R10", 32'h6010_0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_size();
      t_min_and_disable();
      t_xlat();
      t_pass();
      t_prio();
      t_badmask();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule